// File: doc/BRIEF.md
# Shift-Register Column Scan Driver

This block drives a chain of serial-in, parallel-out shift registers that have a latched output stage. Three pins connect it to the chain: a serial data line, a shift clock and a storage strobe. A keyboard matrix scanner uses it to pull exactly one column low at a time, or to release every column. The scanner issues one of three commands: load a raw 16-bit word, select a column by its index, or deselect everything.

The block turns each command into a 16-bit word. It sends that word least significant bit first. Every bit is framed by a rising and a falling shift-clock edge. After the last bit, a strobe pulse copies the word to the parallel outputs. Every level on the pins is held for a programmable number of system-clock cycles, so slow or distant register chains can be driven reliably. A busy flag covers the whole transfer. A single-cycle completion pulse then tells the scanner that the new column pattern is on the outputs and that row sampling can start.

Top module: `colscan_driver`

## Requirements
- R1: A command is taken only in a cycle where cmd_valid is high and busy is low. A cmd_valid pulse that arrives while busy is high is ignored: it starts no transfer and does not change the word being sent.
- R2: Each transfer clocks exactly 16 bits onto sr_data, least significant bit first. The k-th rising edge of sr_clk carries word bit k.
- R3: Each bit is advanced by taking sr_clk high and then low. sr_data does not change in the cycle in which sr_clk rises.
- R4: sr_latch is low before the first sr_clk rise. It rises only after the 16th bit has been clocked, while sr_clk is low, and it then returns low before busy falls.
- R5: Column select (cmd_op = 2'b01) produces an active-low one-hot word in which index i clears bit 15-i and sets all other bits. Index 0 clears bit 15 and index 15 clears bit 0.
- R6: Deselect (cmd_op = 2'b10 or 2'b11) sends 16'hFFFF.
- R7: A column index of 16 or more on the 5-bit cmd_col sends 16'hFFFF.
- R8: Every high level of sr_clk and of sr_latch lasts max(D,1) system cycles, where D is cmd_delay sampled at acceptance. busy stays high for exactly 36*max(D,1) cycles.
- R9: A delay of 0 behaves exactly like a delay of 1.
- R10: After reset, sr_clk, sr_data, sr_latch, busy and done are all low.
- R11: done is high for exactly one cycle, in the first cycle in which busy is low after a transfer.
- R12: Raw write (cmd_op = 2'b00) sends cmd_word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 raw word, 01 column select, 10/11 deselect all |
| cmd_word | input | 16 | Word for a raw write |
| cmd_col | input | 5 | Column index for column select |
| cmd_delay | input | 16 | Cycles per pin level (0 is treated as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the strobe has returned low |
| sr_data | output | 1 | Serial data to the register chain |
| sr_clk | output | 1 | Shift clock |
| sr_latch | output | 1 | Storage strobe |

## Verification
The bench decodes the pin activity back into a word, using its own model of the register chain, and compares it with the word computed from the command. Raw words with asymmetric bit patterns expose a reversed bit order. Column indices 0 and 15 expose an index mapping that is not mirrored, and indices 16 and 31 separate a range check from plain truncation. Delays of 0, 1 and 3 separate the minimum-phase rule from the true per-level pacing. A command pulse sent in the middle of a transfer shows whether acceptance is correctly blocked while busy. Random commands with random delays cover the remaining combinations.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

    // Command opcodes presented on cmd_op
    typedef enum logic [1:0] {
        OP_RAW   = 2'b00,
        OP_COL   = 2'b01,
        OP_CLR_A = 2'b10,
        OP_CLR_B = 2'b11
    } op_e;

    // Pin phases of one transfer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FRAME,
        PH_SETUP,
        PH_HIGH,
        PH_TAIL,
        PH_STROBE,
        PH_RELEASE
    } phase_e;

    typedef struct packed {
        logic sdat;
        logic sclk;
        logic slat;
    } pins_t;

    // Phase length minus one; a zero request still gives one cycle
    function automatic logic [15:0] span_m1(input logic [15:0] d);
        return (d == 16'd0) ? 16'd0 : d - 16'd1;
    endfunction

endpackage

// File: rtl/colscan_encode.sv
module colscan_encode
    import colscan_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W) + 1
) (
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] raw,
    input  logic [IDX_W-1:0]  col,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] col_word;

    // Index i pulls bit WORD_W-1-i low; out-of-range indices match nothing
    for (genvar i = 0; i < WORD_W; i++) begin : g_col
        assign col_word[WORD_W-1-i] = (col != IDX_W'(i));
    end

    always_comb begin
        unique case (op_e'(op))
            OP_RAW:  word = raw;
            OP_COL:  word = col_word;
            default: word = '1;
        endcase
    end
endmodule

// File: rtl/colscan_pacer.sv
module colscan_pacer
    import colscan_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             reload,
    input  logic [DLY_W-1:0] dly,
    output logic             tick
);
    logic [DLY_W-1:0] per_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] first;

    assign first = DLY_W'(span_m1(16'(dly)));
    assign tick  = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
            cnt_q <= '0;
        end else if (start) begin
            per_q <= first;
            cnt_q <= first;
        end else if (reload) begin
            cnt_q <= per_q;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/colscan_sequencer.sv
module colscan_sequencer
    import colscan_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [WORD_W-1:0] word_in,
    input  logic              tick,
    output logic              start,
    output logic              reload,
    output logic              active,
    output logic              done,
    output pins_t             pins
);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

    phase_e            ph_q;
    logic [WORD_W-1:0] sh_q;
    logic [BIT_W-1:0]  idx_q;
    logic              done_q;

    assign active = (ph_q != PH_IDLE);
    assign start  = req && !active;
    assign reload = active && tick;
    assign done   = done_q;

    always_comb begin
        pins.sclk = (ph_q == PH_HIGH);
        pins.slat = (ph_q == PH_STROBE);
        pins.sdat = (ph_q == PH_SETUP || ph_q == PH_HIGH) ? sh_q[0] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            sh_q   <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                ph_q  <= PH_FRAME;
                sh_q  <= word_in;
                idx_q <= '0;
            end else if (reload) begin
                unique case (ph_q)
                    PH_FRAME:  ph_q <= PH_SETUP;
                    PH_SETUP:  ph_q <= PH_HIGH;
                    PH_HIGH: begin
                        if (idx_q == LAST) begin
                            ph_q <= PH_TAIL;
                        end else begin
                            ph_q  <= PH_SETUP;
                            idx_q <= idx_q + 1'b1;
                            sh_q  <= sh_q >> 1;
                        end
                    end
                    PH_TAIL:   ph_q <= PH_STROBE;
                    PH_STROBE: ph_q <= PH_RELEASE;
                    PH_RELEASE: begin
                        ph_q   <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                    default:   ph_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/colscan_driver.sv
module colscan_driver
    import colscan_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DLY_W  = 16,
    localparam int IDX_W = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [IDX_W-1:0]  cmd_col,
    input  logic [DLY_W-1:0]  cmd_delay,
    output logic              busy,
    output logic              done,
    output logic              sr_data,
    output logic              sr_clk,
    output logic              sr_latch
);
    logic [WORD_W-1:0] enc_word;
    logic              tick, start, reload, active;
    pins_t             pins;

    colscan_encode #(.WORD_W(WORD_W)) enc_i (
        .op  (cmd_op),
        .raw (cmd_word),
        .col (cmd_col),
        .word(enc_word)
    );

    colscan_pacer #(.DLY_W(DLY_W)) pace_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .reload(reload),
        .dly   (cmd_delay),
        .tick  (tick)
    );

    colscan_sequencer #(.WORD_W(WORD_W)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .req    (cmd_valid),
        .word_in(enc_word),
        .tick   (tick),
        .start  (start),
        .reload (reload),
        .active (active),
        .done   (done),
        .pins   (pins)
    );

    assign busy     = active;
    assign sr_data  = pins.sdat;
    assign sr_clk   = pins.sclk;
    assign sr_latch = pins.slat;
endmodule

// File: rtl/colscan_driver_chk.sv
module colscan_driver_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic sr_data,
    input logic sr_clk,
    input logic sr_latch
);
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (!sr_clk && !sr_latch && !busy && !done && !sr_data));

    assert_accept_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    assert_data_stable_at_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_clk) |-> $stable(sr_data));

    assert_strobe_clear_of_clock_R4: assert property (@(posedge clk) disable iff (rst)
        !(sr_clk && sr_latch));

    assert_pins_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sr_clk && !sr_latch));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

bind colscan_driver colscan_driver_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .done     (done),
    .sr_data  (sr_data),
    .sr_clk   (sr_clk),
    .sr_latch (sr_latch)
);

// File: tb/colscan_driver_tb_top.sv
module colscan_driver_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_word = '0;
    logic [4:0]  cmd_col = '0;
    logic [15:0] cmd_delay = '0;
    logic        busy, done, sr_data, sr_clk, sr_latch;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    colscan_driver dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_col(cmd_col), .cmd_delay(cmd_delay),
        .busy(busy), .done(done), .sr_data(sr_data), .sr_clk(sr_clk),
        .sr_latch(sr_latch)
    );

    // Bench model of the register chain, sampled away from the clock edge
    logic [15:0] rx = '0;
    logic [15:0] got_word = '0;
    int bits = 0, bits_at_latch = 0;
    int hi_len = 0, lat_len = 0, busy_cyc = 0, width_bad = 0, order_bad = 0;
    int exp_span = 1, latches = 0;
    logic pclk = 0, plat = 0, pdat = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cyc++;
            if (sr_clk && !pclk) begin
                if (sr_latch || sr_data !== pdat) order_bad++;
                rx = {sr_data, rx[15:1]};
                bits++;
            end
            if (sr_clk) hi_len++;
            if (!sr_clk && pclk) begin
                if (hi_len != exp_span) width_bad++;
                hi_len = 0;
            end
            if (sr_latch && !plat) begin
                got_word = rx;
                bits_at_latch = bits;
                if (sr_clk) order_bad++;
            end
            if (sr_latch) lat_len++;
            if (!sr_latch && plat) begin
                if (lat_len != exp_span) width_bad++;
                lat_len = 0;
                latches++;
            end
        end
        pclk = sr_clk; plat = sr_latch; pdat = sr_data;
    end

    function automatic logic [15:0] model(input logic [1:0] op, input logic [15:0] w,
                                          input logic [4:0] c);
        if (op == 2'b00) return w;
        if (op == 2'b01) return (c < 5'd16) ? ~(16'h8000 >> c) : 16'hFFFF;
        return 16'hFFFF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] w, input logic [4:0] c,
                         input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_col = c; cmd_delay = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Runs one command to completion and checks the decoded result
    task automatic run(input logic [1:0] op, input logic [15:0] w, input logic [4:0] c,
                       input logic [15:0] d, input string req, input bit mid_poke);
        logic [15:0] exp;
        int n, lat0;
        exp = model(op, w, c);
        exp_span = (d == 0) ? 1 : int'(d);
        busy_cyc = 0; bits = 0; width_bad = 0; order_bad = 0; lat0 = latches;
        issue(op, w, c, d);
        if (mid_poke) begin
            // R1: a command during busy must be ignored
            cmd_valid = 1'b1; cmd_op = 2'b00; cmd_word = ~exp; cmd_delay = 16'd7;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check(done === 1'b1, "R11 done seen", done, 1);
        check(busy === 1'b0, "R11 busy low with done", busy, 0);
        check(got_word == exp, {req, " word"}, got_word, exp);
        check(bits_at_latch == 16, "R2/R4 bits before strobe", bits_at_latch, 16);
        check(busy_cyc == 36 * exp_span, "R8 busy length", busy_cyc, 36 * exp_span);
        check(width_bad == 0, "R8 level widths", width_bad, 0);
        check(order_bad == 0, "R3 data stable, R4 strobe order", order_bad, 0);
        check(latches == lat0 + 1, "R4 one strobe", latches - lat0, 1);
        @(negedge clk);
        check(done === 1'b0, "R11 done one cycle", done, 0);
        check(busy === 1'b0, "R1 no second transfer", busy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({sr_clk, sr_data, sr_latch, busy, done} == 5'b0, "R10 reset state",
              {sr_clk, sr_data, sr_latch, busy, done}, 0);
        // R1: valid held low starts nothing
        repeat (4) @(negedge clk);
        check(busy === 1'b0, "R1 idle without valid", busy, 0);

        run(2'b00, 16'hA5C3, 5'd0, 16'd2, "R12 R2 raw", 1'b0);
        run(2'b00, 16'h0001, 5'd0, 16'd1, "R12 R2 lsb", 1'b0);
        run(2'b01, 16'h0000, 5'd0, 16'd1, "R5 col0", 1'b0);
        run(2'b01, 16'h0000, 5'd15, 16'd1, "R5 col15", 1'b0);
        run(2'b01, 16'h0000, 5'd6, 16'd2, "R5 col6", 1'b0);
        run(2'b01, 16'h1234, 5'd16, 16'd1, "R7 col16", 1'b0);
        run(2'b01, 16'h1234, 5'd31, 16'd1, "R7 col31", 1'b0);
        run(2'b10, 16'h0000, 5'd3, 16'd1, "R6 clr10", 1'b0);
        run(2'b11, 16'h0F0F, 5'd3, 16'd1, "R6 clr11", 1'b0);
        run(2'b00, 16'h8001, 5'd0, 16'd0, "R9 zero delay", 1'b0);
        run(2'b01, 16'h0000, 5'd9, 16'd3, "R8 delay3", 1'b0);
        run(2'b00, 16'h3C5A, 5'd0, 16'd2, "R1 poke busy", 1'b1);

        for (int i = 0; i < 25; i++) begin
            run(2'($urandom), 16'($urandom), 5'($urandom), 16'($urandom_range(0, 4)),
                "R2 random", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule